// File: doc/BRIEF.md
# Boot and Power Control Registers

A small register block for a four-core device, reached over a plain synchronous register bus with address, write enable, write data, read enable and read data. It holds one boot-complete flag per core, a 32-bit power-state word, and one NMI trigger register per core. Boot code on each core raises its own flag just before handing over to application code. After a wake-up, the boot code reads the power-state word to learn which low-power mode the device left and where to resume. Writing 1 to a core's NMI trigger register sends a single-cycle non-maskable interrupt pulse to that core.

The block has two reset inputs. The power-on reset clears everything. The general device reset clears everything except the power-state word, so the word survives a warm reset. Both resets are asserted asynchronously and released synchronously.

Top module: `boot_pwr_csr`

## Requirements
- R1: After power-on reset, the boot flags, the power-state word, the NMI pulses and `rd_data` are all 0.
- R2: A write to byte address 0x00 sets every boot flag whose bit is 1 in `wr_data[3:0]` (bit n is core n). A read of 0x00 returns the flags in bits 3:0 and 0 in bits 31:4.
- R3: Boot flags are sticky. Writing 0 to a flag leaves it at 1, and only a reset clears it.
- R4: The general device reset clears the boot flags, the NMI pulses and `rd_data`, and leaves the power-state word unchanged.
- R5: Byte address 0x04 holds the 32-bit power-state word, fully read/write. Bit 0 is standby, bit 1 is hibernation, bit 2 selects the hibernation mode (0 is mode 1, 1 is mode 2), and bits 31:3 hold the resume start address. Without a write to 0x04 the word does not change.
- R6: The power-on reset clears the power-state word.
- R7: A write with `wr_data[0]`=1 to byte address 0x08+4n (n = 0..3) drives `nmi_pulse[n]` high for exactly the one cycle after the write. Writes in consecutive cycles give pulses in consecutive cycles.
- R8: A write with `wr_data[0]`=0 to an NMI trigger address produces no pulse.
- R9: A read of an NMI trigger address returns 0 and produces no pulse.
- R10: Any other address, including addresses that are not word aligned, reads 0. Writes to such an address change no flag or word and produce no pulse.
- R11: `rd_data` carries the value read in the cycle after `rd_en` is high, and is 0 in any cycle after a cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| dev_rst_n | input | 1 | General device reset, active low, asynchronous assert |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| nmi_pulse | output | 4 | Per-core NMI pulse, one cycle wide |
| boot_done | output | 4 | Current boot-complete flags |
| pwr_word | output | 32 | Current power-state word |

## Verification
Every result is due exactly one clock edge after the accepting edge:
- Flags, the power word and NMI pulses change at the edge that samples the write.
- Read data appears at the edge that samples `rd_en`.

The bench drives inputs on the falling edge and samples on the next falling edge, which falls inside that one-cycle window. For a pulse, it also samples one falling edge later to confirm the pulse has dropped. After a reset is released, the bench waits for the release to pass through the synchronizer stages before it makes any check.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int unsigned CSR_W      = 32;
  localparam int unsigned BOOT_OFF   = 0;
  localparam int unsigned PWR_OFF    = 4;
  localparam int unsigned NMI_BASE   = 8;
  localparam int unsigned NMI_STRIDE = 4;

  // byte offset of the NMI trigger register of core idx
  function automatic int unsigned nmi_offset(input int unsigned idx);
    return NMI_BASE + NMI_STRIDE * idx;
  endfunction
endpackage

// File: rtl/bpc_rst_sync.sv
module bpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/bpc_addr_dec.sv
module bpc_addr_dec
  import bpc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 boot_sel,
  output logic                 pwr_sel,
  output logic [NUM_CORES-1:0] nmi_sel
);
  assign boot_sel = (addr == ADDR_W'(BOOT_OFF));
  assign pwr_sel  = (addr == ADDR_W'(PWR_OFF));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_nmi
    assign nmi_sel[i] = (addr == ADDR_W'(nmi_offset(i)));
  end
endmodule

// File: rtl/bpc_boot_flags.sv
module bpc_boot_flags #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_sel,
  input  logic [NUM_CORES-1:0] wr_bits,
  output logic [NUM_CORES-1:0] flags
);
  logic [NUM_CORES-1:0] set_req;
  assign set_req = wr_sel ? wr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags | set_req;
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    // R3
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] |=> flags[i]);
    // R2
    boot_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(wr_sel && wr_bits[i]));
  end
endmodule

// File: rtl/bpc_pwr_state.sv
module bpc_pwr_state
  import bpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (wr_sel) word <= wr_data;
  end

  // R5
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(word));
  // R5
  pwr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> word == $past(wr_data));
endmodule

// File: rtl/bpc_nmi_gen.sv
module bpc_nmi_gen #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 trig_bit,
  input  logic [NUM_CORES-1:0] nmi_sel,
  output logic [NUM_CORES-1:0] pulse
);
  logic fire;
  assign fire = wr_en & trig_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= fire ? nmi_sel : '0;
  end

  // R7
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    // R7
    nmi_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && nmi_sel[i]) |=> pulse[i]);
    // R8
    nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |-> $past(wr_en && trig_bit && nmi_sel[i]));
  end
endmodule

// File: rtl/boot_pwr_csr.sv
module boot_pwr_csr
  import bpc_pkg::*;
#(
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 dev_rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [CSR_W-1:0]     wr_data,
  input  logic                 rd_en,
  output logic [CSR_W-1:0]     rd_data,
  output logic [NUM_CORES-1:0] nmi_pulse,
  output logic [NUM_CORES-1:0] boot_done,
  output logic [CSR_W-1:0]     pwr_word
);
  localparam int unsigned PAD_W = CSR_W - NUM_CORES;

  logic por_rst_n, dev_rst_sync_n, dev_arst_n;
  logic boot_sel, pwr_sel;
  logic [NUM_CORES-1:0] nmi_sel;
  logic [CSR_W-1:0] rd_next;

  // the device reset is also asserted by the power-on reset
  assign dev_arst_n = por_n & dev_rst_n;

  bpc_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .rst_n(por_rst_n));
  bpc_rst_sync #(.STAGES(SYNC_STAGES)) u_dev_sync (
    .clk(clk), .arst_n(dev_arst_n), .rst_n(dev_rst_sync_n));

  bpc_addr_dec #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .boot_sel(boot_sel), .pwr_sel(pwr_sel), .nmi_sel(nmi_sel));

  bpc_boot_flags #(.NUM_CORES(NUM_CORES)) u_boot (
    .clk(clk), .rst_n(dev_rst_sync_n), .wr_sel(wr_en & boot_sel),
    .wr_bits(wr_data[NUM_CORES-1:0]), .flags(boot_done));

  bpc_pwr_state u_pwr (
    .clk(clk), .rst_n(por_rst_n), .wr_sel(wr_en & pwr_sel),
    .wr_data(wr_data), .word(pwr_word));

  bpc_nmi_gen #(.NUM_CORES(NUM_CORES)) u_nmi (
    .clk(clk), .rst_n(dev_rst_sync_n), .wr_en(wr_en), .trig_bit(wr_data[0]),
    .nmi_sel(nmi_sel), .pulse(nmi_pulse));

  // NMI trigger registers and unmapped addresses read as zero
  always_comb begin
    rd_next = '0;
    if (boot_sel)     rd_next = {{PAD_W{1'b0}}, boot_done};
    else if (pwr_sel) rd_next = pwr_word;
  end

  always_ff @(posedge clk or negedge dev_rst_sync_n) begin
    if (!dev_rst_sync_n) rd_data <= '0;
    else                 rd_data <= rd_en ? rd_next : '0;
  end

  // R9
  nmi_read_zero_chk: assert property (@(posedge clk) disable iff (!dev_rst_sync_n)
    (rd_en && (|nmi_sel)) |=> rd_data == '0);
  // R11
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!dev_rst_sync_n)
    !rd_en |=> rd_data == '0);
  // R2
  boot_read_pad_chk: assert property (@(posedge clk) disable iff (!dev_rst_sync_n)
    (rd_en && boot_sel) |=> rd_data[CSR_W-1:NUM_CORES] == '0);
  // R4
  pwr_warm_keep_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!dev_rst_sync_n && !(wr_en && pwr_sel)) |=> $stable(pwr_word));
endmodule

// File: tb/boot_pwr_csr_bench.sv
module boot_pwr_csr_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, dev_rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, pwr_word;
  logic [3:0] nmi_pulse, boot_done;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boot_pwr_csr u_boot_pwr_csr (
    .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .nmi_pulse(nmi_pulse), .boot_done(boot_done), .pwr_word(pwr_word));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic warm_reset();
    @(negedge clk); dev_rst_n = 1'b0; idle(2); dev_rst_n = 1'b1; idle(4);
  endtask

  task automatic cold_reset();
    @(negedge clk); por_n = 1'b0; idle(2); por_n = 1'b1; idle(4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats [8];
    pats = '{32'h1, 32'h2, 32'h4, 32'hFFFF_FFF8, 32'hAAAA_AAAA,
             32'h5555_5555, 32'hFFFF_FFFF, 32'h0};
    idle(3); por_n = 1'b1; dev_rst_n = 1'b1; idle(4);

    // R1 reset state
    chk("R1 boot", {28'd0, boot_done}, 32'd0);
    chk("R1 pwr", pwr_word, 32'd0);
    chk("R1 nmi", {28'd0, nmi_pulse}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    rd(8'h00, d); chk("R1 read boot", d, 32'd0);
    rd(8'h04, d); chk("R1 read pwr", d, 32'd0);

    // R2 / R3 exhaustive over flag patterns
    for (int v = 0; v < 16; v++) begin
      warm_reset();
      wr(8'h00, {28'hFFF_FFFF, 4'(v)});
      chk("R2 set", {28'd0, boot_done}, 32'(v));
      rd(8'h00, d); chk("R2 read", d, 32'(v));
      wr(8'h00, 32'd0);
      chk("R3 zero keeps", {28'd0, boot_done}, 32'(v));
      wr(8'h00, {28'd0, ~4'(v)});
      chk("R3 merge", {28'd0, boot_done}, 32'hF);
    end

    // R11 read latency and idle zero
    wr(8'h04, 32'hCAFE_0001);
    @(negedge clk); addr = 8'h04; rd_en = 1'b1;
    chk("R11 before", rd_data, 32'd0);
    @(negedge clk); rd_en = 1'b0;
    chk("R11 due", rd_data, 32'hCAFE_0001);
    @(negedge clk);
    chk("R11 idle", rd_data, 32'd0);

    // R5 power word patterns
    foreach (pats[i]) begin
      wr(8'h04, pats[i]);
      chk("R5 word", pwr_word, pats[i]);
      rd(8'h04, d); chk("R5 read", d, pats[i]);
    end

    // R4 warm reset keeps the power word
    wr(8'h04, 32'hDEAD_BEE5);
    wr(8'h00, 32'hF);
    warm_reset();
    chk("R4 boot cleared", {28'd0, boot_done}, 32'd0);
    chk("R4 pwr kept", pwr_word, 32'hDEAD_BEE5);
    rd(8'h04, d); chk("R4 read pwr", d, 32'hDEAD_BEE5);

    // R6 cold reset clears everything
    wr(8'h00, 32'h6);
    cold_reset();
    chk("R6 pwr cleared", pwr_word, 32'd0);
    chk("R6 boot cleared", {28'd0, boot_done}, 32'd0);

    // R7 / R8 / R9 per-core NMI
    for (int n = 0; n < 4; n++) begin
      wr(8'(8 + 4 * n), (n % 2 == 0) ? 32'h1 : 32'hFFFF_FFFF);
      chk("R7 pulse", {28'd0, nmi_pulse}, 32'(1 << n));
      @(negedge clk);
      chk("R7 one cycle", {28'd0, nmi_pulse}, 32'd0);
      wr(8'(8 + 4 * n), 32'hFFFF_FFFE);
      chk("R8 no pulse", {28'd0, nmi_pulse}, 32'd0);
      rd(8'(8 + 4 * n), d);
      chk("R9 read zero", d, 32'd0);
      chk("R9 no pulse", {28'd0, nmi_pulse}, 32'd0);
    end

    // R7 back-to-back
    @(negedge clk); addr = 8'h08; wr_data = 32'h1; wr_en = 1'b1;
    @(negedge clk); addr = 8'h0C;
    chk("R7 b2b first", {28'd0, nmi_pulse}, 32'h1);
    @(negedge clk); addr = 8'h14;
    chk("R7 b2b second", {28'd0, nmi_pulse}, 32'h2);
    @(negedge clk); wr_en = 1'b0;
    chk("R7 b2b third", {28'd0, nmi_pulse}, 32'h8);
    @(negedge clk);
    chk("R7 b2b end", {28'd0, nmi_pulse}, 32'd0);

    // R10 unmapped and misaligned addresses
    wr(8'h04, 32'h1234_5678);
    wr(8'h00, 32'h5);
    for (int a = 8'h18; a <= 8'hFC; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
      if (nmi_pulse != 4'd0) chk("R10 no pulse", {28'd0, nmi_pulse}, 32'd0);
      rd(8'(a), d);
      if (d != 32'd0) chk("R10 read zero", d, 32'd0);
    end
    foreach (pats[i]) begin
      logic [7:0] ma;
      ma = 8'(1 + 2 * i);
      wr(ma, 32'hFFFF_FFFF);
      chk("R10 misaligned no pulse", {28'd0, nmi_pulse}, 32'd0);
      rd(ma, d); chk("R10 misaligned read", d, 32'd0);
    end
    chk("R10 boot unchanged", {28'd0, boot_done}, 32'h5);
    chk("R10 pwr unchanged", pwr_word, 32'h1234_5678);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule